// File: doc/BRIEF.md
# Select-Gated Bit Memory Array

An N×N array of single-bit storage cells addressed by a row index and a column index. Each cell keeps its stored bit apart from the value it drives. A deselected cell holds its data and drives 0. Because of this, the outputs of all cells can be merged by a plain OR into one read bit, and any number of select lines can be routed across the array without disturbing unselected cells.

Inside a cell, the next stored value comes from a 2-to-1 mux. The mux is steered by the AND of the cell's select and the write strobe, and it picks between the incoming data bit and the present contents. The cell output is that mux result gated by the select. As a result, a write shows the new data on the read bit in the same cycle it is written, and a read shows the stored bit.

The array decodes the row and column indices into one-hot vectors and ANDs them, together with an array-level enable, to form each cell's select. The stored bits update on the rising clock edge. An active-low asynchronous reset clears every cell.

Top module: `selgate_ram_array`

## Requirements
- R1: While rst_ni is low, all cells clear to 0. After reset, a read of any address returns 0 until that address is written.
- R2: When en_i is 0, rdata_o is 0. No cell changes at the clock edge, whatever we_i, the address or wdata_i hold.
- R3: When en_i is 1 and we_i is 0, rdata_o equals the stored bit of the cell at (row_i, col_i) in the same cycle, and no cell changes.
- R4: When en_i is 1 and we_i is 1, rdata_o equals wdata_i in the same cycle (write-through).
- R5: A write cycle stores wdata_i into the addressed cell at the rising clock edge. A later read of that address returns it.
- R6: A write changes only the cell at (row_i, col_i). All other cells keep their contents.
- R7: The cell selected is the one whose row is row_i and whose column is col_i. When en_i is 1 and both indices are below N, exactly one cell is selected. When en_i is 0, none is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all cells |
| en_i | input | 1 | Array enable; 0 deselects every cell |
| we_i | input | 1 | 1 = write, 0 = read |
| row_i | input | $clog2(N) | Row index |
| col_i | input | $clog2(N) | Column index |
| wdata_i | input | 1 | Data bit to write |
| rdata_o | output | 1 | OR of all cell outputs |

## Verification
rdata_o is combinational from the inputs and the stored bits. Read and write-through results are therefore due in the same cycle as the stimulus. The bench samples them one time unit after it drives the inputs, which is well before the next rising edge. A write takes effect at the first rising edge after it is presented. Stored contents are checked only from the following cycle onward, either by a later read or by a full sweep of the array that compares every cell with the scoreboard. The sweeps after the disabled cycles and after the random phase confirm that no cell other than the addressed one changed.

// File: rtl/selgate_ram_pkg.sv
package selgate_ram_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gated_bit_cell.sv
module gated_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic wr_i,
  input  logic d_i,
  output logic dout_o
);
  logic q_q, upd, nxt;

  assign upd    = sel_i & wr_i;
  assign nxt    = upd ? d_i : q_q;
  assign dout_o = sel_i & nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= nxt;
  end

  p_cell_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> (q_q == $past(d_i)));
  p_cell_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> $stable(q_q));
  p_cell_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (dout_o == 1'b0));
endmodule

// File: rtl/index_decoder.sv
module index_decoder #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] idx_i,
  output logic [N-1:0]  hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = en_i && (idx_i == AW'(i));
  end

  p_dec_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (int'(idx_i) < N)) |-> ($countones(hot_o) == 1));
  p_dec_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (hot_o == '0));
endmodule

// File: rtl/or_combine.sv
module or_combine #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8
) (
  input  logic [ROWS*COLS-1:0] bits_i,
  output logic                 any_o
);
  logic [ROWS-1:0] row_any;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_any[r] = |bits_i[r*COLS +: COLS];
  end

  assign any_o = |row_any;
endmodule

// File: rtl/selgate_ram_array.sv
module selgate_ram_array
  import selgate_ram_pkg::*;
#(
  parameter  int unsigned N  = 8,
  localparam int unsigned AW = idx_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] row_i,
  input  logic [AW-1:0] col_i,
  input  logic          wdata_i,
  output logic          rdata_o
);
  localparam int unsigned CELLS = N * N;

  logic [N-1:0]     row_hot, col_hot;
  logic [CELLS-1:0] sel, cell_out;

  index_decoder #(.N(N), .AW(AW)) u_row_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .idx_i(row_i), .hot_o(row_hot)
  );
  index_decoder #(.N(N), .AW(AW)) u_col_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .idx_i(col_i), .hot_o(col_hot)
  );

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N; c++) begin : g_c
      assign sel[r*N+c] = row_hot[r] & col_hot[c];
      gated_bit_cell u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sel_i (sel[r*N+c]),
        .wr_i  (we_i),
        .d_i   (wdata_i),
        .dout_o(cell_out[r*N+c])
      );
    end
  end

  or_combine #(.ROWS(N), .COLS(N)) u_or (.bits_i(cell_out), .any_o(rdata_o));

  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_off_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (rdata_o == 1'b0));
  p_write_through_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |-> (rdata_o == wdata_i));
endmodule

// File: tb/selgate_ram_array_bench.sv
module selgate_ram_array_bench;
  localparam int N  = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, we = 0, wd = 0;
  logic [AW-1:0] row = '0, col = '0;
  logic rd;

  int checks = 0, errors = 0;
  bit model [N*N];
  bit done = 0;

  always #4 clk = ~clk;

  selgate_ram_array #(.N(N)) u_selgate_ram_array (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .we_i(we),
    .row_i(row), .col_i(col), .wdata_i(wd), .rdata_o(rd)
  );

  function automatic bit expect_rd(bit e, bit w, int r, int c, bit d);
    if (!e) return 1'b0;
    if (w)  return d;
    return model[r*N+c];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational result, commit at posedge
  task automatic op(string req, bit e, bit w, int r, int c, bit d);
    @(negedge clk);
    en = e; we = w; row = AW'(r); col = AW'(c); wd = d;
    #1;
    chk(req, rd, expect_rd(e, w, r, c, d));
    @(posedge clk);
    if (e && w) model[r*N+c] = d;
  endtask

  task automatic sweep(string req);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        op(req, 1, 0, r, c, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240901));
    for (int i = 0; i < N*N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    sweep("R1 reset contents");

    // directed write-through, store and read-back
    op("R4 write-through 1", 1, 1, 0, 0, 1);
    op("R3 readback corner 0,0", 1, 0, 0, 0, 0);
    op("R4 write-through far", 1, 1, N-1, N-1, 1);
    op("R5 readback far", 1, 0, N-1, N-1, 0);
    op("R6 neighbour untouched", 1, 0, N-1, N-2, 0);
    op("R7 row/col not swapped", 1, 1, 2, 5, 1);
    op("R7 transposed cell", 1, 0, 5, 2, 0);
    op("R7 addressed cell", 1, 0, 2, 5, 0);
    op("R4 write-through 0", 1, 1, 0, 0, 0);
    op("R5 overwrite to 0", 1, 0, 0, 0, 0);

    // disabled cycles with write strobe must change nothing
    for (int i = 0; i < 16; i++)
      op("R2 disabled output zero", 0, 1, $urandom_range(N-1), $urandom_range(N-1), 1);
    sweep("R2 no change while disabled");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      bit e, w;
      e = ($urandom_range(9) != 0);
      w = $urandom_range(1);
      op(w ? "R4 random write" : "R3 random read", e, w,
         $urandom_range(N-1), $urandom_range(N-1), $urandom_range(1));
    end
    sweep("R6 full array after random");

    // async reset clears everything
    @(negedge clk); rst_ni = 1'b0;
    for (int i = 0; i < N*N; i++) model[i] = 0;
    @(negedge clk); rst_ni = 1'b1;
    sweep("R1 reset after writes");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule